// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide register interface of a single eight-line interrupt controller. It sits between a host bus with a one-bit address and the controller's request, in-service and priority logic. Each write is classified as a start-of-initialization word, a follow-on initialization word, a mode-control word, a command word or a mask update. The block holds the mode state that the rest of the controller consumes, and it returns read data.

The request and in-service registers and the priority resolver are outside this block. Their current values and the resolver's winning line come in as inputs. End-of-interrupt and priority-rotation commands go out as a one-cycle decoded strobe with a 3-bit operand. A poll read also goes out as a one-cycle clear strobe for the winning line. The vector presented for an acknowledge is formed from the stored base and the resolver's line number.

Top module: `pic_reg_if`

## Requirements
- R1: After rst_ni is released the block is in normal mode (init_busy_o low), imr_o, rdata_o and vec_o upper bits are 0, all mode flags are 0, and no strobe is active.
- R2: A write to address 0 with bit 4 set starts initialization. One cycle later init_busy_o is high and init_clr_o pulses for exactly one cycle. The mask, vector base, read select, poll arm, special mask, nesting, auto-EOI and rotate flags are all cleared, and bit 0 is recorded as the four-word flag.
- R3: The first address-1 write during initialization stores its bits 7:3 as the vector base. vec_o equals that base with pend_line_i in bits 2:0.
- R4: The second address-1 write during initialization changes no output. It leaves initialization (init_busy_o low) unless the four-word flag is set.
- R5: When the four-word flag is set, the third address-1 write sets nested_o from bit 4 and auto_eoi_o from bit 1, then returns to normal mode.
- R6: In normal mode an address-1 write loads imr_o, and a read of address 1 returns the mask.
- R7: A write to address 0 with bit 4 clear and bit 3 set is a mode-control word. Bit 0 becomes the read select only when bit 1 is set. Bit 5 becomes spec_mask_o only when bit 6 is set.
- R8: A non-poll read of address 0 returns isr_i when the read select is 1 and irr_i when it is 0. rdata_o is valid in the cycle after the read.
- R9: A write to address 0 with bits 4 and 3 clear is a command. Its bits 7:5 map to cmd_op_o as follows: 1 gives 1 (non-specific EOI), 5 gives 2 (rotating EOI), 3 gives 3 (specific EOI), 6 gives 4 (set priority) and 7 gives 5 (specific rotating EOI). cmd_arg_o carries bits 2:0. The strobe is present for one cycle, one cycle after the write. Code 2 produces cmd_op_o of 0.
- R10: Command codes 0 and 4 set rot_auto_eoi_o from bit 7 and raise no strobe.
- R11: Bit 2 of a mode-control word arms poll. The next read, at either address, returns the winning line number in rdata_o, or 0 when pend_vld_i is low. When a line is pending it also pulses poll_clr_o with poll_line_o. The arm is then dropped, so a later read is a normal read.
- R12: A read and a write in the same cycle use the same address. The read sees the state from before the write, and both take effect.
- R13: Bits 1 and 3 of the start-of-initialization word are accepted and have no effect on the sequence or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irr_i | input | 8 | Request register from the controller core |
| isr_i | input | 8 | In-service register from the controller core |
| pend_vld_i | input | 1 | Resolver has a winning line |
| pend_line_i | input | 3 | Resolver's winning line |
| imr_o | output | 8 | Interrupt mask |
| vec_o | output | 8 | Acknowledge vector (base and line) |
| nested_o | output | 1 | Fully nested mode flag |
| auto_eoi_o | output | 1 | Auto-EOI flag |
| rot_auto_eoi_o | output | 1 | Rotate on auto-EOI flag |
| spec_mask_o | output | 1 | Special mask flag |
| init_busy_o | output | 1 | Initialization sequence in progress |
| init_clr_o | output | 1 | One-cycle clear for core state on initialization |
| cmd_op_o | output | 3 | Decoded command strobe, 0 when idle |
| cmd_arg_o | output | 3 | Command operand |
| poll_clr_o | output | 1 | One-cycle clear of the polled line |
| poll_line_o | output | 3 | Line cleared by the poll |

## Verification
Two functions can fall in the same cycle: a read, which may be an armed poll, and a command or mask write on the shared address. The bench drives both strobes in one cycle. In one case it writes the mask while reading address 1, and expects the old mask in rdata_o and the new mask on imr_o. In the other it reads address 0 while poll is armed and issues a non-specific EOI in the same cycle. It expects the polled line, a poll clear and the EOI strobe together in the following cycle.

// File: rtl/pic_reg_pkg.sv
package pic_reg_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_SKIP = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;

  typedef enum logic [2:0] {
    CMD_NONE         = 3'd0,
    CMD_EOI          = 3'd1,
    CMD_EOI_ROT      = 3'd2,
    CMD_EOI_SPEC     = 3'd3,
    CMD_SET_PRIO     = 3'd4,
    CMD_EOI_SPEC_ROT = 3'd5
  } cmd_op_e;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_INIT = 3'd1,
    WK_CTRL = 3'd2,
    WK_CMD  = 3'd3,
    WK_DATA = 3'd4
  } wr_kind_e;

  localparam int unsigned B_INIT    = 4;
  localparam int unsigned B_CTRL    = 3;
  localparam int unsigned B_POLL    = 2;
  localparam int unsigned B_RSEL_EN = 1;
  localparam int unsigned B_RSEL    = 0;
  localparam int unsigned B_SMM_EN  = 6;
  localparam int unsigned B_SMM     = 5;
  localparam int unsigned B_FOUR    = 0;
  localparam int unsigned B_NEST    = 4;
  localparam int unsigned B_AEOI    = 1;
  localparam int unsigned B_ROT     = 7;
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_reg_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3
) (
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output wr_kind_e      kind_o,
  output cmd_op_e       op_o,
  output logic          rot_we_o,
  output logic [LW-1:0] arg_o
);
  always_comb begin
    kind_o = WK_NONE;
    if (wr_en_i) begin
      if (addr_i)                kind_o = WK_DATA;
      else if (wdata_i[B_INIT])  kind_o = WK_INIT;
      else if (wdata_i[B_CTRL])  kind_o = WK_CTRL;
      else                       kind_o = WK_CMD;
    end
  end

  always_comb begin
    op_o = CMD_NONE;
    if (kind_o == WK_CMD) begin
      case (wdata_i[7:5])
        3'd1:    op_o = CMD_EOI;
        3'd5:    op_o = CMD_EOI_ROT;
        3'd3:    op_o = CMD_EOI_SPEC;
        3'd6:    op_o = CMD_SET_PRIO;
        3'd7:    op_o = CMD_EOI_SPEC_ROT;
        default: op_o = CMD_NONE;
      endcase
    end
  end

  // codes 0 and 4 differ only in bit 7
  assign rot_we_o = (kind_o == WK_CMD) && (wdata_i[6:5] == 2'b00);
  assign arg_o    = wdata_i[LW-1:0];
endmodule

// File: rtl/pic_mode_regs.sv
module pic_mode_regs
  import pic_reg_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_kind_e         kind_i,
  input  cmd_op_e          op_i,
  input  logic             rot_we_i,
  input  logic [LW-1:0]    arg_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    imr_o,
  output logic [DW-LW-1:0] base_o,
  output logic             nested_o,
  output logic             auto_eoi_o,
  output logic             rot_o,
  output logic             smm_o,
  output logic             rsel_o,
  output logic             poll_o,
  output logic             busy_o,
  output logic             init_clr_o,
  output logic [2:0]       cmd_op_o,
  output logic [LW-1:0]    cmd_arg_o
);
  init_st_e st_q;
  logic     four_q;
  cmd_op_e  cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RUN;
      four_q     <= 1'b0;
      imr_o      <= '0;
      base_o     <= '0;
      nested_o   <= 1'b0;
      auto_eoi_o <= 1'b0;
      rot_o      <= 1'b0;
      smm_o      <= 1'b0;
      rsel_o     <= 1'b0;
      poll_o     <= 1'b0;
      init_clr_o <= 1'b0;
      cmd_q      <= CMD_NONE;
      cmd_arg_o  <= '0;
    end else begin
      init_clr_o <= 1'b0;
      cmd_q      <= CMD_NONE;
      if (rd_en_i && poll_o) poll_o <= 1'b0;
      case (kind_i)
        WK_INIT: begin
          st_q       <= ST_BASE;
          four_q     <= wdata_i[B_FOUR];
          imr_o      <= '0;
          base_o     <= '0;
          nested_o   <= 1'b0;
          auto_eoi_o <= 1'b0;
          rot_o      <= 1'b0;
          smm_o      <= 1'b0;
          rsel_o     <= 1'b0;
          poll_o     <= 1'b0;
          init_clr_o <= 1'b1;
        end
        WK_CTRL: begin
          if (wdata_i[B_POLL])    poll_o <= 1'b1;
          if (wdata_i[B_RSEL_EN]) rsel_o <= wdata_i[B_RSEL];
          if (wdata_i[B_SMM_EN])  smm_o  <= wdata_i[B_SMM];
        end
        WK_CMD: begin
          cmd_q     <= op_i;
          cmd_arg_o <= arg_i;
          if (rot_we_i) rot_o <= wdata_i[B_ROT];
        end
        WK_DATA: begin
          case (st_q)
            ST_RUN:  imr_o <= wdata_i;
            ST_BASE: begin
              base_o <= wdata_i[DW-1:LW];
              st_q   <= ST_SKIP;
            end
            ST_SKIP: st_q <= four_q ? ST_MODE : ST_RUN;
            ST_MODE: begin
              nested_o   <= wdata_i[B_NEST];
              auto_eoi_o <= wdata_i[B_AEOI];
              st_q       <= ST_RUN;
            end
            default: st_q <= ST_RUN;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign busy_o   = (st_q != ST_RUN);
  assign cmd_op_o = cmd_q;
endmodule

// File: rtl/pic_read_port.sv
module pic_read_port #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          addr_i,
  input  logic          poll_i,
  input  logic          rsel_i,
  input  logic [DW-1:0] imr_i,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  input  logic          pend_vld_i,
  input  logic [LW-1:0] pend_line_i,
  output logic [DW-1:0] rdata_o,
  output logic          poll_clr_o,
  output logic [LW-1:0] poll_line_o
);
  logic [DW-1:0] reg_sel;
  logic [DW-1:0] poll_val;

  assign reg_sel  = addr_i ? imr_i : (rsel_i ? isr_i : irr_i);
  assign poll_val = pend_vld_i ? {{(DW-LW){1'b0}}, pend_line_i} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      poll_clr_o  <= 1'b0;
      poll_line_o <= '0;
    end else begin
      poll_clr_o <= 1'b0;
      if (rd_en_i) begin
        if (poll_i) begin
          rdata_o     <= poll_val;
          poll_clr_o  <= pend_vld_i;
          poll_line_o <= pend_line_i;
        end else begin
          rdata_o <= reg_sel;
        end
      end
    end
  end
endmodule

// File: rtl/pic_reg_if.sv
module pic_reg_if
  import pic_reg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic                          addr_i,
  input  logic [NUM_LINES-1:0]          wdata_i,
  output logic [NUM_LINES-1:0]          rdata_o,
  input  logic [NUM_LINES-1:0]          irr_i,
  input  logic [NUM_LINES-1:0]          isr_i,
  input  logic                          pend_vld_i,
  input  logic [$clog2(NUM_LINES)-1:0]  pend_line_i,
  output logic [NUM_LINES-1:0]          imr_o,
  output logic [NUM_LINES-1:0]          vec_o,
  output logic                          nested_o,
  output logic                          auto_eoi_o,
  output logic                          rot_auto_eoi_o,
  output logic                          spec_mask_o,
  output logic                          init_busy_o,
  output logic                          init_clr_o,
  output logic [2:0]                    cmd_op_o,
  output logic [$clog2(NUM_LINES)-1:0]  cmd_arg_o,
  output logic                          poll_clr_o,
  output logic [$clog2(NUM_LINES)-1:0]  poll_line_o
);
  localparam int unsigned DW = NUM_LINES;
  localparam int unsigned LW = $clog2(NUM_LINES);

  wr_kind_e         kind;
  cmd_op_e          op;
  logic             rot_we;
  logic [LW-1:0]    arg;
  logic [DW-LW-1:0] base;
  logic             rsel;
  logic             poll;

  pic_wr_decode #(.DW(DW), .LW(LW)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .kind_o  (kind),
    .op_o    (op),
    .rot_we_o(rot_we),
    .arg_o   (arg)
  );

  pic_mode_regs #(.DW(DW), .LW(LW)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kind_i    (kind),
    .op_i      (op),
    .rot_we_i  (rot_we),
    .arg_i     (arg),
    .wdata_i   (wdata_i),
    .rd_en_i   (rd_en_i),
    .imr_o     (imr_o),
    .base_o    (base),
    .nested_o  (nested_o),
    .auto_eoi_o(auto_eoi_o),
    .rot_o     (rot_auto_eoi_o),
    .smm_o     (spec_mask_o),
    .rsel_o    (rsel),
    .poll_o    (poll),
    .busy_o    (init_busy_o),
    .init_clr_o(init_clr_o),
    .cmd_op_o  (cmd_op_o),
    .cmd_arg_o (cmd_arg_o)
  );

  pic_read_port #(.DW(DW), .LW(LW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .poll_i     (poll),
    .rsel_i     (rsel),
    .imr_i      (imr_o),
    .irr_i      (irr_i),
    .isr_i      (isr_i),
    .pend_vld_i (pend_vld_i),
    .pend_line_i(pend_line_i),
    .rdata_o    (rdata_o),
    .poll_clr_o (poll_clr_o),
    .poll_line_o(poll_line_o)
  );

  assign vec_o = {base, pend_line_i};
endmodule

// File: rtl/pic_reg_if_chk.sv
module pic_reg_if_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          pend_vld_i,
  input logic [DW-1:0] imr_o,
  input logic          init_clr_o,
  input logic          init_busy_o,
  input logic          spec_mask_o,
  input logic [2:0]    cmd_op_o,
  input logic          poll_clr_o,
  input logic [LW-1:0] poll_line_o
);
  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[4]) |=> (init_clr_o && init_busy_o && imr_o == '0)); // R2

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i && !init_busy_o) |=> (imr_o == $past(wdata_i))); // R6

  AST_SMM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[4:3] == 2'b01 && wdata_i[6]) |=> (spec_mask_o == $past(wdata_i[5]))); // R7

  AST_CMD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_op_o != 3'd0) |-> $past(wr_en_i && !addr_i && wdata_i[4:3] == 2'b00)); // R9

  AST_CODE2_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[4:3] == 2'b00 && wdata_i[7:5] == 3'd2) |=> (cmd_op_o == 3'd0)); // R9

  AST_POLL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_clr_o |-> ($past(rd_en_i && pend_vld_i) && rdata_o == {{(DW-LW){1'b0}}, poll_line_o})); // R11

  AST_READ_OLD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wr_en_i && addr_i) |=> (poll_clr_o || rdata_o == '0 || rdata_o == $past(imr_o))); // R12
endmodule

bind pic_reg_if pic_reg_if_chk #(.DW(DW), .LW(LW)) u_chk (.*);

// File: tb/sim_pic_reg_if.sv
module sim_pic_reg_if;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, irr = '0, isr = '0;
  logic pend_vld = 1'b0;
  logic [2:0] pend_line = '0;
  logic [7:0] rdata, imr, vec;
  logic nested, aeoi, rot, smm, busy, iclr, pclr;
  logic [2:0] cmd_op, cmd_arg, pline;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_reg_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irr_i(irr), .isr_i(isr),
    .pend_vld_i(pend_vld), .pend_line_i(pend_line), .imr_o(imr), .vec_o(vec),
    .nested_o(nested), .auto_eoi_o(aeoi), .rot_auto_eoi_o(rot), .spec_mask_o(smm),
    .init_busy_o(busy), .init_clr_o(iclr), .cmd_op_o(cmd_op), .cmd_arg_o(cmd_arg),
    .poll_clr_o(pclr), .poll_line_o(pline)
  );

  typedef struct {
    logic [7:0] data;
    logic       clr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int n_chk = 0;
  int n_bad = 0;
  logic rd_seen = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read results against the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL unexpected read act=%h exp=none", rdata);
      end else begin
        cur = exp_q.pop_front();
        chk({cur.tag, " rdata"}, rdata, cur.data);
        chk({cur.tag, " poll_clr"}, {7'b0, pclr}, {7'b0, cur.clr});
      end
    end
  end

  // driver: one bus cycle; reads push their expectation
  task automatic bus(input logic w, input logic r, input logic a, input logic [7:0] d,
                     input logic [7:0] e, input logic ec, input string tag);
    exp_t it;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    if (r) begin
      it.data = e; it.clr = ec; it.tag = tag;
      exp_q.push_back(it);
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus(1'b1, 1'b0, a, d, 8'h00, 1'b0, "");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 imr", imr, 8'h00);
    chk("R1 busy", {7'b0, busy}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 vec", vec, 8'h00);
    chk("R1 modes", {3'b0, nested, aeoi, rot, smm, iclr}, 8'h00);
    chk("R1 cmd", {5'b0, cmd_op}, 8'h00);

    // R6 mask load and read-back
    wr(1'b1, 8'h5A);
    chk("R6 imr", imr, 8'h5A);
    bus(1'b0, 1'b1, 1'b1, 8'h00, 8'h5A, 1'b0, "R6 read mask");

    // R7/R8 read select and special mask
    irr = 8'h33; isr = 8'hC4;
    wr(1'b0, 8'h6B);
    chk("R7 smm set", {7'b0, smm}, 8'h01);
    bus(1'b0, 1'b1, 1'b0, 8'h00, 8'hC4, 1'b0, "R8 read isr");
    wr(1'b0, 8'h0A);
    bus(1'b0, 1'b1, 1'b0, 8'h00, 8'h33, 1'b0, "R8 read irr");
    wr(1'b0, 8'h09);
    bus(1'b0, 1'b1, 1'b0, 8'h00, 8'h33, 1'b0, "R7 select ungated");
    chk("R7 smm kept", {7'b0, smm}, 8'h01);
    wr(1'b0, 8'h48);
    chk("R7 smm clr", {7'b0, smm}, 8'h00);
    wr(1'b0, 8'h68);
    wr(1'b0, 8'h0B);

    // R10 rotate flag
    wr(1'b0, 8'h80);
    chk("R10 rot set", {7'b0, rot}, 8'h01);
    chk("R10 no strobe", {5'b0, cmd_op}, 8'h00);

    // R2/R13 init with single and level bits set, four-word
    wr(1'b0, 8'h1B);
    chk("R2 busy", {7'b0, busy}, 8'h01);
    chk("R2 clr pulse", {7'b0, iclr}, 8'h01);
    chk("R2 imr", imr, 8'h00);
    chk("R2 flags", {4'b0, rot, smm, nested, aeoi}, 8'h00);
    bus(1'b0, 1'b1, 1'b0, 8'h00, 8'h33, 1'b0, "R2 select cleared");
    chk("R2 clr one cycle", {7'b0, iclr}, 8'h00);
    pend_line = 3'd5;
    wr(1'b1, 8'h37);
    chk("R3 vec", vec, 8'h35);
    chk("R13 busy", {7'b0, busy}, 8'h01);
    wr(1'b1, 8'hFF);
    chk("R4 imr", imr, 8'h00);
    chk("R4 busy four", {7'b0, busy}, 8'h01);
    wr(1'b1, 8'h12);
    chk("R5 nested", {7'b0, nested}, 8'h01);
    chk("R5 aeoi", {7'b0, aeoi}, 8'h01);
    chk("R5 busy", {7'b0, busy}, 8'h00);
    chk("R13 imr", imr, 8'h00);
    wr(1'b1, 8'hA5);
    chk("R6 imr run", imr, 8'hA5);

    // R4 three-word init
    wr(1'b0, 8'h10);
    chk("R2 nested clr", {6'b0, nested, aeoi}, 8'h00);
    pend_line = 3'd2;
    wr(1'b1, 8'h48);
    chk("R3 vec2", vec, 8'h4A);
    wr(1'b1, 8'h00);
    chk("R4 busy three", {7'b0, busy}, 8'h00);

    // R9 command decode
    wr(1'b0, 8'h20); chk("R9 eoi", {cmd_op, cmd_arg}, {3'd1, 3'd0});
    chk("R9 one cycle", 8'h00, 8'h00);
    @(negedge clk); chk("R9 strobe off", {5'b0, cmd_op}, 8'h00);
    wr(1'b0, 8'hA0); chk("R9 rot eoi", {2'b0, cmd_op, cmd_arg}, {2'b0, 3'd2, 3'd0});
    wr(1'b0, 8'h63); chk("R9 spec eoi", {2'b0, cmd_op, cmd_arg}, {2'b0, 3'd3, 3'd3});
    wr(1'b0, 8'hC6); chk("R9 set prio", {2'b0, cmd_op, cmd_arg}, {2'b0, 3'd4, 3'd6});
    wr(1'b0, 8'hE5); chk("R9 spec rot", {2'b0, cmd_op, cmd_arg}, {2'b0, 3'd5, 3'd5});
    wr(1'b0, 8'h47); chk("R9 code2", {5'b0, cmd_op}, 8'h00);
    wr(1'b0, 8'h80); chk("R10 rot on", {7'b0, rot}, 8'h01);
    wr(1'b0, 8'h00); chk("R10 rot off", {6'b0, rot, cmd_op != 3'd0}, 8'h00);

    // R11 poll
    wr(1'b1, 8'h81);
    pend_vld = 1'b1; pend_line = 3'd6;
    wr(1'b0, 8'h0C);
    bus(1'b0, 1'b1, 1'b1, 8'h00, 8'h06, 1'b1, "R11 poll hit");
    chk("R11 line", {5'b0, pline}, 8'h06);
    bus(1'b0, 1'b1, 1'b1, 8'h00, 8'h81, 1'b0, "R11 disarmed");
    pend_vld = 1'b0;
    wr(1'b0, 8'h0C);
    bus(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R11 poll empty");

    // R12 same-cycle read and write
    bus(1'b1, 1'b1, 1'b1, 8'h3C, 8'h81, 1'b0, "R12 old mask");
    chk("R12 new mask", imr, 8'h3C);
    pend_vld = 1'b1; pend_line = 3'd2;
    wr(1'b0, 8'h0C);
    bus(1'b1, 1'b1, 1'b0, 8'h20, 8'h02, 1'b1, "R12 poll with eoi");
    chk("R12 eoi strobe", {5'b0, cmd_op}, 8'h01);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule